// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is an on-chip word scratchpad split into 16 banks and shared by 16 lanes. A request carries, for every lane, an enable bit, a read/write command, a word address and write data. The block splits each address into a bank and a row, and then serves the request over one or more clock cycles. In each cycle every bank serves exactly one address. All pending lanes that name that address are served together, so many lanes reading the same word cost one slot.

The number of cycles a request takes equals the largest count of distinct addresses that fall into any one bank. Linear and odd-stride patterns therefore finish in one cycle. Power-of-two strides serialize in proportion to how many lanes share a bank. When a request completes, the block raises a single-cycle completion strobe. It also presents the per-lane read data, the cycle count and the number of extra (conflict) cycles, and holds them until the next request is accepted.

Top module: `spm_bank_serializer`

## Requirements
- R1: Word address `a` lives in bank `a mod 16` (the low 4 address bits) at row `a / 16`. A read returns the word last written at that address. Lane `l` uses bits `[l*8 +: 8]` of `req_addr` and bits `[l*32 +: 32]` of `req_wdata` and `rd_data`.
- R2: When every active lane targets a different bank, the request takes one cycle: `cycles_used` = 1 and `conflict_cycles` = 0.
- R3: Lanes reading the identical address are served in the same cycle by broadcast and add no conflict.
- R4: `cycles_used` equals the maximum, over all banks, of the number of distinct addresses the active lanes request in that bank. `conflict_cycles` equals `cycles_used - 1`.
- R5: With 16 lanes, stride 2 costs 2 cycles, stride 8 costs 8 cycles, and stride 17 (an odd, padded row) costs 1 cycle.
- R6: A lane reading an address that another lane of the same request writes receives the value held before the request.
- R7: When several lanes write the same address in one request, the data of the highest-numbered of those lanes is stored.
- R8: `req_valid` while `busy` is high is ignored: no access, no completion, no memory change.
- R9: A request is accepted at a rising edge where `req_valid`=1 and `busy`=0. `busy` is high from the next cycle on. `done` is a one-cycle pulse that appears max(N,1) edges after the accepting edge, where N = `cycles_used`. `busy` is low while `done` is high. Results hold until the next accept.
- R10: After reset, `busy`, `done`, `cycles_used`, `conflict_cycles` and `rd_data` are all zero.
- R11: An inactive lane (`req_active` bit 0) neither reads nor writes. `rd_data` is zero for inactive lanes and for writing lanes (`req_write` bit 1 = write, 0 = read).
- R12: A request with no active lane completes one edge after acceptance, with `cycles_used` = 0 and `conflict_cycles` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken only while busy is low |
| req_active | input | 16 | Per-lane enable |
| req_write | input | 16 | Per-lane command, 1 = write, 0 = read |
| req_addr | input | 128 | Per-lane word address, 8 bits each |
| req_wdata | input | 512 | Per-lane write data, 32 bits each |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 512 | Per-lane read data, valid from done |
| cycles_used | output | 5 | Serving cycles of the last request |
| conflict_cycles | output | 5 | Serving cycles beyond the first |

## Verification
Every result of a request is due at the edge where done rises. That edge is max(N,1) clock edges after the accepting edge, with N the worst per-bank count of distinct addresses that the bench computes from its own memory model. The driver records the cycle number of the accepting edge alongside the expected values. The monitor samples on falling edges, so it reads done, rd_data and both counters in the cycle they become valid and measures the latency against that record. Results that must persist, and writes offered while busy, are checked later through plain read requests and the held counters.

// File: rtl/spm_pkg.sv
package spm_pkg;
   // Per-lane command encoding carried on req_write.
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } lane_op_e;
endpackage

// File: rtl/spm_bank_store.sv
module spm_bank_store #(
   parameter int ROWS   = 16,
   parameter int WORD_W = 32,
   parameter int ROW_W  = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  row,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [ROWS];

   // Read is combinational on the current row, so a read sharing a cycle
   // with a write to the same row observes the old word.
   always_ff @(posedge clk) begin
      if (wr_en) mem[row] <= wr_data;
   end

   assign rd_data = mem[row];
endmodule

// File: rtl/spm_bank_pick.sv
module spm_bank_pick #(
   parameter int LANES   = 16,
   parameter int ADDR_W  = 8,
   parameter int WORD_W  = 32,
   parameter int BIDX_W  = 4,
   parameter int ROW_W   = 4,
   parameter int BANK_ID = 0
) (
   input  logic [LANES-1:0]        pending,
   input  logic [LANES*BIDX_W-1:0] lane_bank,
   input  logic [LANES*ROW_W-1:0]  lane_row,
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   input  logic [LANES-1:0]        lane_write,
   input  logic [LANES*WORD_W-1:0] lane_wdata,
   output logic [LANES-1:0]        serve,
   output logic [ROW_W-1:0]        lead_row,
   output logic                    wr_en,
   output logic [WORD_W-1:0]       wr_data
);
   logic [LANES-1:0]  in_bank;
   logic [ADDR_W-1:0] lead_addr;
   logic              found;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         in_bank[l] = pending[l] &&
                      (lane_bank[l*BIDX_W +: BIDX_W] == BIDX_W'(BANK_ID));
      end
   end

   // Lowest-numbered pending lane of this bank leads the cycle.
   always_comb begin
      found     = 1'b0;
      lead_addr = '0;
      lead_row  = '0;
      for (int l = 0; l < LANES; l++) begin
         if (in_bank[l] && !found) begin
            found     = 1'b1;
            lead_addr = lane_addr[l*ADDR_W +: ADDR_W];
            lead_row  = lane_row[l*ROW_W +: ROW_W];
         end
      end
   end

   // Every pending lane naming the leader's word rides along.
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         serve[l] = in_bank[l] && (lane_addr[l*ADDR_W +: ADDR_W] == lead_addr);
      end
   end

   // Ascending scan: the highest served writer wins.
   always_comb begin
      wr_en   = 1'b0;
      wr_data = '0;
      for (int l = 0; l < LANES; l++) begin
         if (serve[l] && lane_write[l]) begin
            wr_en   = 1'b1;
            wr_data = lane_wdata[l*WORD_W +: WORD_W];
         end
      end
   end
endmodule

// File: rtl/spm_round_ctrl.sv
module spm_round_ctrl #(
   parameter int LANES = 16,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LANES-1:0] req_active,
   input  logic [LANES-1:0] served,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output logic [LANES-1:0] pending,
   output logic [CNT_W-1:0] rounds,
   output logic [CNT_W-1:0] extra
);
   logic [LANES-1:0] rest;

   assign rest   = pending & ~served;
   assign accept = req_valid & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         pending <= '0;
         rounds  <= '0;
         extra   <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            pending <= req_active;
            rounds  <= '0;
            extra   <= '0;
         end else if (busy) begin
            pending <= rest;
            if (|served) begin
               rounds <= rounds + CNT_W'(1);
               if (rounds != '0) extra <= extra + CNT_W'(1);
            end
            if (rest == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spm_bank_serializer.sv
module spm_bank_serializer
   import spm_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int BANKS  = 16,
   parameter int ROWS   = 16,
   parameter int WORD_W = 32,
   localparam int ADDR_W = $clog2(BANKS*ROWS),
   localparam int CNT_W  = $clog2(LANES+1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [LANES-1:0]        req_active,
   input  logic [LANES-1:0]        req_write,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES*WORD_W-1:0] req_wdata,
   output logic                    busy,
   output logic                    done,
   output logic [LANES*WORD_W-1:0] rd_data,
   output logic [CNT_W-1:0]        cycles_used,
   output logic [CNT_W-1:0]        conflict_cycles
);
   localparam int BIDX_W = $clog2(BANKS);
   localparam int ROW_W  = $clog2(ROWS);
   localparam bit POW2   = ((BANKS & (BANKS-1)) == 0);

   if (LANES < 1) begin : g_chk_lanes
      $error("spm_bank_serializer: LANES must be at least 1");
   end
   if (BANKS < 2) begin : g_chk_banks
      $error("spm_bank_serializer: BANKS must be at least 2");
   end
   if (ROWS < 2) begin : g_chk_rows
      $error("spm_bank_serializer: ROWS must be at least 2");
   end
   if (WORD_W < 1) begin : g_chk_word
      $error("spm_bank_serializer: WORD_W must be at least 1");
   end

   logic                    accept;
   logic [LANES-1:0]        pending;
   logic [LANES-1:0]        served_any;
   logic [LANES*ADDR_W-1:0] hold_addr;
   logic [LANES-1:0]        hold_write;
   logic [LANES*WORD_W-1:0] hold_wdata;
   logic [LANES*BIDX_W-1:0] lane_bank;
   logic [LANES*ROW_W-1:0]  lane_row;
   logic [LANES*WORD_W-1:0] rd_q;
   logic [LANES-1:0]        bank_serve [BANKS];
   logic [ROW_W-1:0]        bank_row   [BANKS];
   logic                    bank_wr_en [BANKS];
   logic [WORD_W-1:0]       bank_wdata [BANKS];
   logic [WORD_W-1:0]       bank_rd    [BANKS];

   // Request capture at acceptance.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_addr  <= '0;
         hold_write <= '0;
         hold_wdata <= '0;
      end else if (accept) begin
         hold_addr  <= req_addr;
         hold_write <= req_write;
         hold_wdata <= req_wdata;
      end
   end

   // Address split: bit slice for power-of-two banking, divide otherwise.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [ADDR_W-1:0] a;
      assign a = hold_addr[l*ADDR_W +: ADDR_W];
      if (POW2) begin : g_slice
         assign lane_bank[l*BIDX_W +: BIDX_W] = a[BIDX_W-1:0];
         assign lane_row[l*ROW_W +: ROW_W]    = ROW_W'(a >> BIDX_W);
      end else begin : g_divide
         assign lane_bank[l*BIDX_W +: BIDX_W] = BIDX_W'(a % BANKS);
         assign lane_row[l*ROW_W +: ROW_W]    = ROW_W'(a / BANKS);
      end
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      spm_bank_pick #(
         .LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
         .BIDX_W(BIDX_W), .ROW_W(ROW_W), .BANK_ID(b)
      ) u_pick (
         .pending   (pending),
         .lane_bank (lane_bank),
         .lane_row  (lane_row),
         .lane_addr (hold_addr),
         .lane_write(hold_write),
         .lane_wdata(hold_wdata),
         .serve     (bank_serve[b]),
         .lead_row  (bank_row[b]),
         .wr_en     (bank_wr_en[b]),
         .wr_data   (bank_wdata[b])
      );

      spm_bank_store #(
         .ROWS(ROWS), .WORD_W(WORD_W), .ROW_W(ROW_W)
      ) u_store (
         .clk    (clk),
         .wr_en  (bank_wr_en[b]),
         .row    (bank_row[b]),
         .wr_data(bank_wdata[b]),
         .rd_data(bank_rd[b])
      );
   end

   always_comb begin
      served_any = '0;
      for (int b = 0; b < BANKS; b++) served_any = served_any | bank_serve[b];
   end

   spm_round_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_active(req_active),
      .served    (served_any),
      .accept    (accept),
      .busy      (busy),
      .done      (done),
      .pending   (pending),
      .rounds    (cycles_used),
      .extra     (conflict_cycles)
   );

   // Read return: each reading lane takes its bank's word in its serving cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (accept) begin
         rd_q <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (served_any[l] && (lane_op_e'(hold_write[l]) == OP_READ)) begin
               rd_q[l*WORD_W +: WORD_W] <= bank_rd[lane_bank[l*BIDX_W +: BIDX_W]];
            end
         end
      end
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/spm_serializer_checker.sv
module spm_serializer_checker #(
   parameter int LANES = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] cycles_used,
   input logic [CNT_W-1:0] conflict_cycles
);
   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> ($stable(cycles_used) && $stable(conflict_cycles)));

   assert_conflict_rel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cycles_used != '0) |-> (conflict_cycles == cycles_used - CNT_W'(1)));

   assert_cycles_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(cycles_used) <= LANES));

   assert_empty_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cycles_used == '0) |-> (conflict_cycles == '0));
endmodule

bind spm_bank_serializer spm_serializer_checker #(
   .LANES(LANES), .CNT_W(CNT_W)
) i_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .busy           (busy),
   .done           (done),
   .cycles_used    (cycles_used),
   .conflict_cycles(conflict_cycles)
);

// File: tb/test_spm_bank_serializer.sv
module test_spm_bank_serializer;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 16;
   localparam int BANKS  = 16;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 8;
   localparam int CNT_W  = 5;
   localparam int WORDS  = 256;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    req_valid = 1'b0;
   logic [LANES-1:0]        req_active = '0;
   logic [LANES-1:0]        req_write = '0;
   logic [LANES*ADDR_W-1:0] req_addr = '0;
   logic [LANES*WORD_W-1:0] req_wdata = '0;
   logic                    busy, done;
   logic [LANES*WORD_W-1:0] rd_data;
   logic [CNT_W-1:0]        cycles_used, conflict_cycles;

   spm_bank_serializer i_spm_bank_serializer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_active(req_active), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data),
      .cycles_used(cycles_used), .conflict_cycles(conflict_cycles)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;

   typedef struct packed {
      logic [31:0]             ncyc;
      logic [31:0]             ncnf;
      logic [31:0]             c0;
      logic [LANES*WORD_W-1:0] rd;
   } exp_t;

   exp_t  sb[$];
   string tag_q[$];

   logic [WORD_W-1:0] mem_m [WORDS];
   logic [LANES-1:0]  s_act, s_wr;
   logic [ADDR_W-1:0] s_addr [LANES];
   logic [WORD_W-1:0] s_data [LANES];

   task automatic chk(input string what, input logic [LANES*WORD_W-1:0] act,
                      input logic [LANES*WORD_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   function automatic logic [WORD_W-1:0] fill_val(input int a);
      return WORD_W'(32'h5A00_0000 + a * 32'h0001_0003);
   endfunction

   // Driver: model the request from the requirements, then issue it.
   task automatic send(input string tag);
      exp_t e;
      int   maxd = 0;
      e = '0;
      for (int b = 0; b < BANKS; b++) begin
         int cnt = 0;
         for (int l = 0; l < LANES; l++) begin
            bit dup = 0;
            if (!s_act[l] || (int'(s_addr[l]) % BANKS) != b) continue;
            for (int k = 0; k < l; k++)
               if (s_act[k] && s_addr[k] == s_addr[l]) dup = 1;
            if (!dup) cnt++;
         end
         if (cnt > maxd) maxd = cnt;
      end
      e.ncyc = 32'(maxd);
      e.ncnf = (maxd > 0) ? 32'(maxd - 1) : 32'd0;
      for (int l = 0; l < LANES; l++)
         if (s_act[l] && !s_wr[l]) e.rd[l*WORD_W +: WORD_W] = mem_m[s_addr[l]];
      for (int l = 0; l < LANES; l++)
         if (s_act[l] && s_wr[l]) mem_m[s_addr[l]] = s_data[l];
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid  = 1'b1;
      req_active = s_act;
      req_write  = s_wr;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*ADDR_W +: ADDR_W]  = s_addr[l];
         req_wdata[l*WORD_W +: WORD_W] = s_data[l];
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      e.c0 = 32'(cyc);
      sb.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic set_stride(input int base, input int stride, input bit wr);
      for (int l = 0; l < LANES; l++) begin
         s_addr[l] = ADDR_W'(base + l * stride);
         s_data[l] = fill_val(base + l * stride);
      end
      s_act = '1;
      s_wr  = wr ? '1 : '0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   // Monitor: pop and compare when done is seen.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            if (sb.size() == 0) begin
               chk("R8 R9 completion with no accepted request", 1, 0);
            end else begin
               exp_t  e;
               string t;
               int    lat_exp;
               e = sb.pop_front();
               t = tag_q.pop_front();
               lat_exp = (e.ncyc == 0) ? 1 : int'(e.ncyc);
               chk({t, " R4 cycles_used"}, (LANES*WORD_W)'(cycles_used), (LANES*WORD_W)'(e.ncyc));
               chk({t, " R4 conflict_cycles"}, (LANES*WORD_W)'(conflict_cycles), (LANES*WORD_W)'(e.ncnf));
               chk({t, " R9 done latency"}, (LANES*WORD_W)'(cyc - int'(e.c0)), (LANES*WORD_W)'(lat_exp));
               chk({t, " R1 rd_data"}, rd_data, e.rd);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 busy/done after reset", {busy, done}, 0);
      chk("R10 counters after reset", {cycles_used, conflict_cycles}, 0);
      chk("R10 rd_data after reset", rd_data, 0);

      // R2 R11: fill every word with a conflict-free linear write
      for (int k = 0; k < WORDS / LANES; k++) begin
         set_stride(k * LANES, 1, 1'b1);
         send("R2 R11 linear fill");
      end

      set_stride(48, 1, 1'b0);  send("R1 R2 linear read");
      set_stride(37, 0, 1'b0);  send("R3 broadcast read");
      set_stride(0, 2, 1'b0);   send("R5 stride 2");
      set_stride(0, 8, 1'b0);   send("R5 stride 8");
      drain();
      repeat (3) @(negedge clk);
      chk("R9 counters held after completion", (LANES*WORD_W)'(cycles_used), 8);
      chk("R9 busy low after completion", (LANES*WORD_W)'(busy), 0);
      set_stride(0, 17, 1'b0);  send("R5 stride 17");

      // R4 R8: full bank conflict, with writes offered while busy
      set_stride(0, 16, 1'b0);  send("R4 stride 16");
      req_valid  = 1'b1;
      req_active = '1;
      req_write  = '1;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*ADDR_W +: ADDR_W]  = ADDR_W'(240 + l);
         req_wdata[l*WORD_W +: WORD_W] = 32'hDEAD_0000 + 32'(l);
      end
      repeat (5) @(negedge clk);
      req_valid = 1'b0;

      // R4 R11: three distinct words in bank 5, inactive lanes carry writes
      s_act = 16'h003F;
      s_wr  = 16'hFFC0;
      for (int l = 0; l < LANES; l++) begin
         s_addr[l] = ADDR_W'(96 + l);
         s_data[l] = 32'hBAD0_0000 + 32'(l);
      end
      for (int l = 0; l < 4; l++) s_addr[l] = 8'd5;
      s_addr[4] = 8'd21;
      s_addr[5] = 8'd37;
      send("R4 R11 mixed bank-5 pattern");

      // R7: all lanes write one word
      set_stride(200, 0, 1'b1);
      for (int l = 0; l < LANES; l++) s_data[l] = 32'hC0DE_0000 + 32'(l);
      send("R7 same-word writes");
      set_stride(200, 0, 1'b0); send("R7 readback");

      // R6: read and write of one word in one request
      s_act = 16'h0007;
      s_wr  = 16'h0001;
      s_addr[0] = 8'd50; s_data[0] = 32'h1234_5678;
      s_addr[1] = 8'd50; s_data[1] = '0;
      s_addr[2] = 8'd66; s_data[2] = '0;
      send("R6 read with same-word write");
      set_stride(50, 0, 1'b0);  send("R6 readback");

      // R12: empty request
      s_act = '0;
      s_wr  = '0;
      send("R12 empty request");

      set_stride(240, 1, 1'b0); send("R8 readback of ignored writes");
      set_stride(96, 1, 1'b0);  send("R11 readback of inactive writes");

      drain();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule